// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the horizontal and vertical timing for a synchronous TFT panel. It runs on the pixel clock and drives the panel sync lines. It also drives a data-enable that marks the visible window, and it exposes the running pixel and line positions so that a pixel fetch unit can follow the raster. A one-cycle frame-start pulse marks the raster origin, which lets the fetch logic restart at the top of its buffer.

Timing is set by four configuration words and a polarity vector. The horizontal and vertical words each hold a period and a sync width, both coded as the value minus one. The vertical word also has a flag that selects whether the vertical sync width is counted in lines or in pixel clocks. A position word gives the offsets at which the visible window starts. A size word gives the window's width and height. The block copies all configuration into shadow registers at the raster origin, so software can rewrite the inputs at any time without tearing the frame that is on screen.

Top module: `lcd_sync_timing`

## Requirements
- R1: While reset is asserted, h_pos_o and v_pos_o are 0, frame_start_o is 0, and hsync_o, vsync_o and de_o are all 0.
- R2: The pixel counter h_pos_o steps by one per clock, from 0 up to the value in hcfg_i[25:16], and then returns to 0. A line therefore lasts that field plus one clocks.
- R3: The line counter v_pos_o advances by one when the pixel counter wraps. It returns to 0 after the line whose number equals vcfg_i[25:16]. It holds its value at all other times.
- R4: frame_start_o is high for exactly the cycles in which both counters are 0. The first such cycle is the first cycle after the first clock edge that follows reset release.
- R5: hsync is active while h_pos_o is at most hcfg_i[31:26]. It is therefore active for that field plus one clocks at the start of every line.
- R6: When vcfg_i[0] is 1, vsync is active on every cycle of the lines 0 to vcfg_i[31:26].
- R7: When vcfg_i[0] is 0, vsync is active only on line 0, while h_pos_o is at most vcfg_i[31:26].
- R8: de is active only when both conditions hold. The first is that h_pos_o lies in [win_pos_i[31:16], win_pos_i[31:16] + act_size_i[31:16]). The second is that v_pos_o lies in [win_pos_i[15:0], win_pos_i[15:0] + act_size_i[15:0]).
- R9: If the window extends past the end of a line or a frame, de is cut off at that boundary. The count of de cycles per frame is the part of the window that lies inside the period.
- R10: The output level of each signal is its active state XOR a polarity bit. pol_i[0] applies to hsync, pol_i[1] to vsync and pol_i[2] to de. With polarity 0 the signal is active-high.
- R11: Changes to any configuration input, polarity included, have no effect until the next raster origin. From that origin on, the new values apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcfg_i | input | 32 | Horizontal word: [31:26] sync width-1, [25:16] period-1 |
| vcfg_i | input | 32 | Vertical word: [31:26] sync width-1, [25:16] period-1, [0] sync counted in lines |
| win_pos_i | input | 32 | Window start: [31:16] pixel offset, [15:0] line offset |
| act_size_i | input | 32 | Window size: [31:16] width in pixels, [15:0] height in lines |
| pol_i | input | 3 | Inversion bits: [0] hsync, [1] vsync, [2] de |
| hsync_o | output | 1 | Horizontal sync, after polarity |
| vsync_o | output | 1 | Vertical sync, after polarity |
| de_o | output | 1 | Data-enable, after polarity |
| h_pos_o | output | 10 | Pixel position within the line |
| v_pos_o | output | 10 | Line position within the frame |
| frame_start_o | output | 1 | One-cycle pulse at the raster origin |

## Verification
The assertions assume that the counter limits only change when the shadow is loaded at the origin. When that load happens, the counters are already at zero, so a counter can never be left above a new, smaller period. The configuration inputs themselves may change at any cycle. The stimulus drives them only at the falling edge, and it changes them in the middle of a frame in just one place: the test for deferred loading. The window and sync-width values are chosen so that the expected pattern can be checked on every cycle of two full frames for each configuration.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  // Counter, sync-width and window field widths
  localparam int CNT_W = 10;
  localparam int SW_W  = 6;
  localparam int OFF_W = 16;
  localparam int POL_W = 3;
  // Field positions inside a config word
  localparam int PER_LSB = 16;
  localparam int PER_MSB = PER_LSB + CNT_W - 1;
  localparam int SW_LSB  = PER_MSB + 1;
  localparam int SW_MSB  = SW_LSB + SW_W - 1;

  typedef struct packed {
    logic [CNT_W-1:0] last;   // period minus one
    logic [SW_W-1:0]  sw;     // sync width minus one
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t        hor;
    axis_cfg_t        ver;
    logic             vs_in_lines;
    logic [OFF_W-1:0] h_off;
    logic [OFF_W-1:0] v_off;
    logic [OFF_W-1:0] wid;
    logic [OFF_W-1:0] hgt;
    logic [POL_W-1:0] pol;
  } tim_cfg_t;
endpackage

// File: rtl/lcdt_shadow.sv
module lcdt_shadow
  import lcdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  tim_cfg_t cfg_in,
  output tim_cfg_t cfg_q
);
  tim_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // The shadow changes only on a load cycle
  assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q)) else $error("shadow changed without load");
endmodule

// File: rtl/lcdt_counter.sv
module lcdt_counter
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] h_last,
  input  logic [CNT_W-1:0] v_last,
  output logic [CNT_W-1:0] h_cnt,
  output logic [CNT_W-1:0] v_cnt,
  output logic             line_end,
  output logic             frame_end
);
  logic [CNT_W-1:0] h_d, v_d;

  assign line_end  = (h_cnt == h_last);
  assign frame_end = line_end && (v_cnt == v_last);

  always_comb begin
    h_d = h_cnt;
    v_d = v_cnt;
    if (run) begin
      if (line_end) begin
        h_d = '0;
        v_d = (v_cnt == v_last) ? '0 : v_cnt + 1'b1;
      end else begin
        h_d = h_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= h_d;
      v_cnt <= v_d;
    end
  end

  assert_h_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_end) |=> (h_cnt == $past(h_cnt) + 1'b1))
    else $error("pixel counter did not step");
  assert_h_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_end) |=> (h_cnt == '0)) else $error("pixel counter did not wrap");
  assert_h_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (h_cnt <= h_last)) else $error("pixel counter past period");
  assert_v_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(v_cnt)) else $error("line counter moved mid-line");
endmodule

// File: rtl/lcdt_decode.sv
module lcdt_decode
  import lcdt_pkg::*;
(
  input  logic             armed,
  input  logic [CNT_W-1:0] h_cnt,
  input  logic [CNT_W-1:0] v_cnt,
  input  tim_cfg_t         cfg,
  output logic [POL_W-1:0] lvl     // [0] hsync, [1] vsync, [2] de
);
  localparam int PADW = OFF_W + 1 - CNT_W;

  logic [CNT_W-1:0] hsw, vsw;
  logic [OFF_W:0]   hx, vx, h_end, v_end;
  logic             hs_act, vs_act, h_in, v_in, de_act;
  logic [POL_W-1:0] act;

  assign hsw = {{(CNT_W-SW_W){1'b0}}, cfg.hor.sw};
  assign vsw = {{(CNT_W-SW_W){1'b0}}, cfg.ver.sw};
  assign hx  = {{PADW{1'b0}}, h_cnt};
  assign vx  = {{PADW{1'b0}}, v_cnt};
  assign h_end = {1'b0, cfg.h_off} + {1'b0, cfg.wid};
  assign v_end = {1'b0, cfg.v_off} + {1'b0, cfg.hgt};

  always_comb begin
    hs_act = armed && (h_cnt <= hsw);
    if (cfg.vs_in_lines) vs_act = armed && (v_cnt <= vsw);
    else                 vs_act = armed && (v_cnt == '0) && (h_cnt <= vsw);
    h_in   = (hx >= {1'b0, cfg.h_off}) && (hx < h_end);
    v_in   = (vx >= {1'b0, cfg.v_off}) && (vx < v_end);
    de_act = armed && h_in && v_in;
  end

  assign act = {de_act, vs_act, hs_act};

  for (genvar g = 0; g < POL_W; g++) begin : g_pol
    assign lvl[g] = act[g] ^ cfg.pol[g];
  end
endmodule

// File: rtl/lcd_sync_timing.sv
module lcd_sync_timing
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      hcfg_i,
  input  logic [31:0]      vcfg_i,
  input  logic [31:0]      win_pos_i,
  input  logic [31:0]      act_size_i,
  input  logic [POL_W-1:0] pol_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [CNT_W-1:0] h_pos_o,
  output logic [CNT_W-1:0] v_pos_o,
  output logic             frame_start_o
);
  tim_cfg_t         cfg_in, cfg_q;
  logic             armed_q, armed_d, origin_q, origin_d, load;
  logic             line_end, frame_end;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic [POL_W-1:0] lvl;
  logic             unused_cfg_bits;

  assign unused_cfg_bits = ^{hcfg_i[PER_LSB-1:0], vcfg_i[PER_LSB-1:1]};

  always_comb begin
    cfg_in.hor.last    = hcfg_i[PER_MSB:PER_LSB];
    cfg_in.hor.sw      = hcfg_i[SW_MSB:SW_LSB];
    cfg_in.ver.last    = vcfg_i[PER_MSB:PER_LSB];
    cfg_in.ver.sw      = vcfg_i[SW_MSB:SW_LSB];
    cfg_in.vs_in_lines = vcfg_i[0];
    cfg_in.h_off       = win_pos_i[2*OFF_W-1:OFF_W];
    cfg_in.v_off       = win_pos_i[OFF_W-1:0];
    cfg_in.wid         = act_size_i[2*OFF_W-1:OFF_W];
    cfg_in.hgt         = act_size_i[OFF_W-1:0];
    cfg_in.pol         = pol_i;
  end

  // Load on the first cycle out of reset and at every frame wrap
  assign load     = !armed_q || frame_end;
  assign armed_d  = 1'b1;
  assign origin_d = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      origin_q <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      origin_q <= origin_d;
    end
  end

  lcdt_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  lcdt_counter u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (armed_q),
    .h_last    (cfg_q.hor.last),
    .v_last    (cfg_q.ver.last),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .line_end  (line_end),
    .frame_end (frame_end)
  );

  lcdt_decode u_decode (
    .armed (armed_q),
    .h_cnt (h_cnt),
    .v_cnt (v_cnt),
    .cfg   (cfg_q),
    .lvl   (lvl)
  );

  assign hsync_o       = lvl[0];
  assign vsync_o       = lvl[1];
  assign de_o          = lvl[2];
  assign h_pos_o       = h_cnt;
  assign v_pos_o       = v_cnt;
  assign frame_start_o = origin_q;

  assert_start_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (h_pos_o == '0 && v_pos_o == '0))
    else $error("frame start away from origin");
  assert_origin_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && h_pos_o == '0 && v_pos_o == '0) |-> frame_start_o)
    else $error("origin without frame start");
  assert_idle_counters_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (h_pos_o == '0 && v_pos_o == '0 && !frame_start_o))
    else $error("counters moved before arming");
endmodule

// File: tb/test_lcd_sync_timing.sv
`timescale 1ns/1ps
module test_lcd_sync_timing;
  typedef struct packed {
    logic [31:0] hcfg;
    logic [31:0] vcfg;
    logic [31:0] pos;
    logic [31:0] size;
    logic [2:0]  pol;
    logic [15:0] de_per_frame;
  } vec_t;

  // Stimulus words and the expected de count per frame
  localparam vec_t VECS [0:2] = '{
    '{32'h0409_0000, 32'h0005_0001, 32'h0003_0002, 32'h0005_0003, 3'b000, 16'd15},
    '{32'h0007_0000, 32'h0804_0000, 32'h0000_0000, 32'h0008_0005, 3'b111, 16'd40},
    '{32'h0C0B_0000, 32'h0403_0001, 32'h000A_0003, 32'h0005_0004, 3'b010, 16'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] hcfg_i, vcfg_i, win_pos_i, act_size_i;
  logic [2:0]  pol_i;
  logic        hsync_o, vsync_o, de_o, frame_start_o;
  logic [9:0]  h_pos_o, v_pos_o;
  int checks = 0;
  int errors = 0;
  int de_seen;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_sync_timing i_lcd_sync_timing (
    .clk(clk), .rst_n(rst_n), .hcfg_i(hcfg_i), .vcfg_i(vcfg_i),
    .win_pos_i(win_pos_i), .act_size_i(act_size_i), .pol_i(pol_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .h_pos_o(h_pos_o), .v_pos_o(v_pos_o), .frame_start_o(frame_start_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    hcfg_i = v.hcfg; vcfg_i = v.vcfg; win_pos_i = v.pos;
    act_size_i = v.size; pol_i = v.pol;
  endtask

  function automatic int frame_len(input vec_t v);
    return (int'(v.hcfg[25:16]) + 1) * (int'(v.vcfg[25:16]) + 1);
  endfunction

  // Compare every output against the requirement model at raster index p
  task automatic step(input vec_t v, input int p, input string pre, input string de_tag);
    int hl = int'(v.hcfg[25:16]) + 1;
    int vl = int'(v.vcfg[25:16]) + 1;
    int h = p % hl;
    int l = (p / hl) % vl;
    int hsw = int'(v.hcfg[31:26]);
    int vsw = int'(v.vcfg[31:26]);
    int ho = int'(v.pos[31:16]);
    int vo = int'(v.pos[15:0]);
    int w = int'(v.size[31:16]);
    int ht = int'(v.size[15:0]);
    logic hs, vs, de;
    hs = (h <= hsw);
    vs = v.vcfg[0] ? (l <= vsw) : (l == 0 && h <= vsw);
    de = (h >= ho) && (h < ho + w) && (l >= vo) && (l < vo + ht);
    chk({pre, "R2 h_pos"}, 32'(h_pos_o), 32'(h));
    chk({pre, "R3 v_pos"}, 32'(v_pos_o), 32'(l));
    chk({pre, "R4 frame_start"}, 32'(frame_start_o), 32'(h == 0 && l == 0));
    chk({pre, "R5 hsync"}, 32'(hsync_o), 32'(hs ^ v.pol[0]));
    chk({pre, v.vcfg[0] ? "R6 vsync" : "R7 vsync"}, 32'(vsync_o), 32'(vs ^ v.pol[1]));
    chk({pre, de_tag, " de"}, 32'(de_o), 32'(de ^ v.pol[2]));
    if (de_o ^ v.pol[2]) de_seen++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);            // one edge arms the block: origin now
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(VECS[1]);
    repeat (3) @(negedge clk);
    // R1: idle outputs while reset is held, even with all inversions requested
    chk("R1 h_pos", 32'(h_pos_o), 0);
    chk("R1 v_pos", 32'(v_pos_o), 0);
    chk("R1 frame_start", 32'(frame_start_o), 0);
    chk("R1 hsync", 32'(hsync_o), 0);
    chk("R1 vsync", 32'(vsync_o), 0);
    chk("R1 de", 32'(de_o), 0);

    // Table walk: two full frames per vector
    for (int i = 0; i < 3; i++) begin
      apply(VECS[i]);
      do_reset();
      for (int f = 0; f < 2; f++) begin
        de_seen = 0;
        for (int p = 0; p < frame_len(VECS[i]); p++) begin
          if (p > 0 || f > 0) @(negedge clk);
          step(VECS[i], p, "", (i == 2) ? "R9" : "R8");
        end
        chk((i == 2) ? "R9 de count" : "R8 de count", 32'(de_seen), 32'(VECS[i].de_per_frame));
      end
    end

    // R10: all three inverted at the origin of vector 1, where all are active
    apply(VECS[1]);
    do_reset();
    chk("R10 hsync inverted", 32'(hsync_o), 0);
    chk("R10 vsync inverted", 32'(vsync_o), 0);
    chk("R10 de inverted", 32'(de_o), 0);

    // R11: change config mid-frame; old timing holds until the next origin
    apply(VECS[0]);
    do_reset();
    for (int p = 0; p < frame_len(VECS[0]); p++) begin
      if (p > 0) @(negedge clk);
      step(VECS[0], p, "R11 old ", "R8");
      if (p == 29) apply(VECS[1]);
    end
    for (int p = 0; p < frame_len(VECS[1]); p++) begin
      @(negedge clk);
      step(VECS[1], p, "R11 new ", "R8");
    end

    // R1: reset in mid-frame returns the counters to zero
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run h_pos", 32'(h_pos_o), 0);
    chk("R1 mid-run v_pos", 32'(v_pos_o), 0);
    chk("R1 mid-run de", 32'(de_o), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule